// File: doc/BRIEF.md
# Boot-Block Flash Region Guard

This block sits in front of a 128 KB byte-wide flash array and decides, for every program or erase request, which erase region the request lands in and whether it may go ahead. The array is split into four unequal regions: an 8 KB boot region, two 4 KB parameter regions and a 112 KB main region. A static layout strap puts the boot region either at the top or at the bottom of the address space. The other regions mirror around it, so the parameter regions always sit next to the boot region.

Permission depends on three digital protection flags: the level of the powerdown pin, a flag that reports high voltage on that same pin, and a flag that reports the programming supply is below its lockout threshold. The boot region can only be altered while the high-voltage flag is present. A low supply or an asserted powerdown pin locks every region. A request strobe makes the block register the region index and a permit flag, which a downstream write sequencer uses one cycle later. Every refused request sets a sticky protection-error flag, which stays set until software pulses a clear input.

Top module: `bootflash_region_guard`

## Requirements
- R1: With the strap sampled high (top layout), the region index is 0 for 0x1E000–0x1FFFF, 1 for 0x1D000–0x1DFFF, 2 for 0x1C000–0x1CFFF and 3 for 0x00000–0x1BFFF.
- R2: With the strap sampled low (bottom layout), the index is 0 for 0x00000–0x01FFF, 1 for 0x02000–0x02FFF, 2 for 0x03000–0x03FFF and 3 for 0x04000–0x1FFFF.
- R3: `rsp_valid_o` is high exactly one cycle after a cycle with `req_i` high. `region_o` and `permit_o` take that request's result at that point and keep it until the next request.
- R4: A request to region 0 is refused unless `rp_hv_i` is high during the request.
- R5: While `pd_pin_n_i` is low, every request is refused, including one with `rp_hv_i` high.
- R6: While `vpp_low_i` is high, every request is refused, including one with `rp_hv_i` high.
- R7: When `pd_pin_n_i` is high and `vpp_low_i` is low, requests to regions 1, 2 and 3 are permitted whatever the level of `rp_hv_i`.
- R8: The strap is captured while `rst_n` is low. A change of the strap after reset has no effect on decoding until the next reset.
- R9: A refused request sets `prot_err_o` in the same cycle that `rsp_valid_o` rises. The flag stays set across later permitted requests, and it clears one cycle after `err_clr_i` is high. A refusal in the same cycle as a clear leaves the flag set.
- R10: During and right after reset, `rsp_valid_o`, `permit_o` and `prot_err_o` are 0 and `region_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; strap is captured while low |
| layout_top_i | input | 1 | Layout strap: 1 = boot region at top, 0 = at bottom |
| req_i | input | 1 | Program/erase request strobe |
| req_addr_i | input | 17 | Byte address of the request |
| rp_hv_i | input | 1 | High-voltage present on the reset/powerdown pin |
| pd_pin_n_i | input | 1 | Powerdown pin level; 0 = powerdown asserted |
| vpp_low_i | input | 1 | Programming supply below lockout threshold |
| err_clr_i | input | 1 | Clear for the sticky protection error |
| region_o | output | 2 | Region index of last request (0 boot, 1 param A, 2 param B, 3 main) |
| permit_o | output | 1 | Last request permitted |
| rsp_valid_o | output | 1 | One-cycle pulse: region and permit updated |
| prot_err_o | output | 1 | Sticky protection-error flag |

## Verification
A wrong captured layout bit swaps the whole decode at once. The first request near either end of the array then reports the wrong region index on the cycle after its strobe. A permit term that ignores a lock shows up as `permit_o` high on the very next response, and `prot_err_o` then fails to rise. A stuck or mis-cleared error register shows on the cycle after a refusal or after a clear pulse. Boundary addresses on both sides of each region edge expose off-by-one decode faults.

// File: rtl/bootflash_region_guard.sv
module bootflash_region_guard #(
  parameter int ADDR_W    = 17,
  parameter int BOOT_BITS = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              layout_top_i,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              rp_hv_i,
  input  logic              pd_pin_n_i,
  input  logic              vpp_low_i,
  input  logic              err_clr_i,
  output logic [1:0]        region_o,
  output logic              permit_o,
  output logic              rsp_valid_o,
  output logic              prot_err_o
);
  localparam int HI_W = ADDR_W - BOOT_BITS;
  localparam logic [HI_W-1:0] BOOT_HI  = {HI_W{1'b1}};
  localparam logic [HI_W-1:0] PARAM_HI = {{(HI_W-1){1'b1}}, 1'b0};

  logic              layout_top_q;
  logic [ADDR_W-1:0] norm_addr;
  logic [HI_W-1:0]   hi;
  logic [1:0]        idx;
  logic              lock_all, ok;

  // bottom layout is the top layout seen through an inverted address
  assign norm_addr = req_addr_i ^ {ADDR_W{~layout_top_q}};
  assign hi        = norm_addr[ADDR_W-1:BOOT_BITS];

  always_comb begin
    if (hi == BOOT_HI)       idx = 2'd0;
    else if (hi == PARAM_HI) idx = norm_addr[BOOT_BITS-1] ? 2'd1 : 2'd2;
    else                     idx = 2'd3;
  end

  assign lock_all = vpp_low_i | ~pd_pin_n_i;
  assign ok       = ~lock_all & ((idx != 2'd0) | rp_hv_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      layout_top_q <= layout_top_i;
      region_o     <= 2'd0;
      permit_o     <= 1'b0;
      rsp_valid_o  <= 1'b0;
      prot_err_o   <= 1'b0;
    end else begin
      rsp_valid_o <= req_i;
      if (req_i) begin
        region_o <= idx;
        permit_o <= ok;
      end
      if (req_i && !ok)  prot_err_o <= 1'b1;
      else if (err_clr_i) prot_err_o <= 1'b0;
    end
  end
endmodule

module bootflash_region_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_i,
  input logic       rp_hv_i,
  input logic       pd_pin_n_i,
  input logic       vpp_low_i,
  input logic       err_clr_i,
  input logic [1:0] region_o,
  input logic       permit_o,
  input logic       rsp_valid_o,
  input logic       prot_err_o
);
  a_r3_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> rsp_valid_o);
  a_r3_no_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !rsp_valid_o);
  a_r3_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> ($stable(region_o) && $stable(permit_o)));
  a_r4_boot_needs_hv: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !rp_hv_i) |=> !(permit_o && region_o == 2'd0));
  a_r5_pd_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !pd_pin_n_i) |=> !permit_o);
  a_r6_vpp_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && vpp_low_i) |=> !permit_o);
  a_r9_refusal_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !permit_o) |-> prot_err_o);
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_err_o && !err_clr_i) |=> prot_err_o);
endmodule

bind bootflash_region_guard bootflash_region_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .rp_hv_i(rp_hv_i),
  .pd_pin_n_i(pd_pin_n_i), .vpp_low_i(vpp_low_i), .err_clr_i(err_clr_i),
  .region_o(region_o), .permit_o(permit_o), .rsp_valid_o(rsp_valid_o),
  .prot_err_o(prot_err_o)
);

// File: tb/tb_bootflash_region_guard.sv
module tb_bootflash_region_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        layout_top_i = 1'b1;
  logic        req_i = 1'b0;
  logic [16:0] req_addr_i = '0;
  logic        rp_hv_i = 1'b0;
  logic        pd_pin_n_i = 1'b1;
  logic        vpp_low_i = 1'b0;
  logic        err_clr_i = 1'b0;
  logic [1:0]  region_o;
  logic        permit_o, rsp_valid_o, prot_err_o;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  bootflash_region_guard dut (
    .clk(clk), .rst_n(rst_n), .layout_top_i(layout_top_i), .req_i(req_i),
    .req_addr_i(req_addr_i), .rp_hv_i(rp_hv_i), .pd_pin_n_i(pd_pin_n_i),
    .vpp_low_i(vpp_low_i), .err_clr_i(err_clr_i), .region_o(region_o),
    .permit_o(permit_o), .rsp_valid_o(rsp_valid_o), .prot_err_o(prot_err_o)
  );

  function automatic logic [1:0] exp_region(input logic [16:0] a, input logic top);
    if (top) begin
      if (a >= 17'h1E000) return 2'd0;
      if (a >= 17'h1D000) return 2'd1;
      if (a >= 17'h1C000) return 2'd2;
      return 2'd3;
    end
    if (a < 17'h02000) return 2'd0;
    if (a < 17'h03000) return 2'd1;
    if (a < 17'h04000) return 2'd2;
    return 2'd3;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic top);
    @(negedge clk);
    rst_n = 1'b0; layout_top_i = top; req_i = 1'b0; err_clr_i = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_req(input logic [16:0] a);
    @(negedge clk);
    req_i = 1'b1; req_addr_i = a;
    @(negedge clk);
    req_i = 1'b0;
  endtask

  task automatic t_reset;
    do_reset(1'b1);
    check("R10 valid", rsp_valid_o, 0);
    check("R10 permit", permit_o, 0);
    check("R10 err", prot_err_o, 0);
    check("R10 region", region_o, 0);
  endtask

  task automatic t_decode(input logic top, input string tag);
    logic [16:0] pts [10] = '{17'h00000, 17'h01FFF, 17'h02000, 17'h02FFF,
      17'h03000, 17'h03FFF, 17'h04000, 17'h1BFFF, 17'h1C000, 17'h1CFFF};
    logic [16:0] pts2 [6] = '{17'h1D000, 17'h1DFFF, 17'h1E000, 17'h1FFFF,
      17'h10000, 17'h0ABCD};
    do_reset(top);
    rp_hv_i = 1'b1; pd_pin_n_i = 1'b1; vpp_low_i = 1'b0;
    foreach (pts[i]) begin
      do_req(pts[i]);
      check(tag, region_o, exp_region(pts[i], top));
      check({tag, " permit"}, permit_o, 1);
    end
    foreach (pts2[i]) begin
      do_req(pts2[i]);
      check(tag, region_o, exp_region(pts2[i], top));
    end
    rp_hv_i = 1'b0;
  endtask

  task automatic t_hold;
    do_reset(1'b1);
    do_req(17'h1D100);
    check("R3 valid pulse", rsp_valid_o, 1);
    req_addr_i = 17'h00000; pd_pin_n_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R3 valid low", rsp_valid_o, 0);
      check("R3 region held", region_o, 1);
      check("R3 permit held", permit_o, 1);
    end
    pd_pin_n_i = 1'b1;
  endtask

  task automatic t_boot_lock;
    do_reset(1'b1);
    rp_hv_i = 1'b0;
    do_req(17'h1F000);
    check("R4 boot refused", permit_o, 0);
    check("R4 region", region_o, 0);
    rp_hv_i = 1'b1;
    do_req(17'h1F000);
    check("R4 boot with hv", permit_o, 1);
    rp_hv_i = 1'b0;
  endtask

  task automatic t_open;
    do_reset(1'b0);
    rp_hv_i = 1'b0;
    do_req(17'h02800); check("R7 param A", permit_o, 1);
    do_req(17'h03800); check("R7 param B", permit_o, 1);
    do_req(17'h08000); check("R7 main", permit_o, 1);
    check("R7 no err", prot_err_o, 0);
  endtask

  task automatic t_pd;
    do_reset(1'b1);
    rp_hv_i = 1'b1; pd_pin_n_i = 1'b0;
    do_req(17'h00100); check("R5 main refused", permit_o, 0);
    do_req(17'h1E100); check("R5 boot refused", permit_o, 0);
    pd_pin_n_i = 1'b1; rp_hv_i = 1'b0;
  endtask

  task automatic t_vpp;
    do_reset(1'b0);
    rp_hv_i = 1'b1; vpp_low_i = 1'b1;
    do_req(17'h02000); check("R6 param refused", permit_o, 0);
    do_req(17'h00000); check("R6 boot refused", permit_o, 0);
    vpp_low_i = 1'b0; rp_hv_i = 1'b0;
  endtask

  task automatic t_strap;
    do_reset(1'b1);
    @(negedge clk); layout_top_i = 1'b0;
    do_req(17'h1F000); check("R8 strap ignored top", region_o, 0);
    do_req(17'h00000); check("R8 strap ignored low", region_o, 3);
    do_reset(1'b0);
    do_req(17'h00000); check("R8 strap after reset", region_o, 0);
  endtask

  task automatic t_err;
    do_reset(1'b1);
    rp_hv_i = 1'b0;
    do_req(17'h1E000);
    check("R9 set with valid", rsp_valid_o, 1);
    check("R9 set", prot_err_o, 1);
    do_req(17'h00000);
    check("R9 sticky", prot_err_o, 1);
    @(negedge clk); err_clr_i = 1'b1;
    @(negedge clk); err_clr_i = 1'b0;
    check("R9 cleared", prot_err_o, 0);
    @(negedge clk); err_clr_i = 1'b1; req_i = 1'b1; req_addr_i = 17'h1E000;
    @(negedge clk); err_clr_i = 1'b0; req_i = 1'b0;
    check("R9 set beats clear", prot_err_o, 1);
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_decode(1'b1, "R1 top decode");
    t_decode(1'b0, "R2 bottom decode");
    t_hold();
    t_boot_lock();
    t_open();
    t_pd();
    t_vpp();
    t_strap();
    t_err();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule